// File: doc/BRIEF.md
# Taken-Branch Micro Target Buffer

This block is a small target cache that sits beside the fetch stage. It answers, in the same cycle as the fetch address, whether that address is a branch that was recently taken and, if so, where fetch should go next. This removes the bubble that would otherwise follow a taken branch while the slower main predictor works. Every entry can hold any branch address, because the tags are compared in parallel across the whole array. Entries are created only from branch resolutions that were actually taken.

A second, slower opinion comes from the main predictor through the override port. When that opinion contradicts an entry that matches, the main predictor wins. The block raises a correction with the address fetch must restart from, and it repairs the entry: a branch the main predictor calls not taken is dropped, and a different target overwrites the stored one. New entries go to the lowest-numbered free slot. When the array is full, a tree pseudo-LRU picks the victim, and both lookup hits and allocations count as recent use.

The allocate port is a valid/ready stream. `alloc_ready` falls in any cycle where `ovr_valid` is high, so the override repair always wins the single write slot. A source that sees `alloc_ready` low must hold `alloc_pc`, `alloc_target` and `alloc_taken` stable until a cycle with `alloc_ready` high. A transfer happens only on a cycle where both `alloc_valid` and `alloc_ready` are high. Fetch lookup and override are plain single-cycle strobes.

Top module: `taken_target_buffer`

## Requirements
- R1: After reset the buffer is empty: every lookup misses, `fix_valid` is 0 and `alloc_ready` is 1 while `ovr_valid` is 0.
- R2: With `fetch_valid` high, `pred_hit` and `pred_target` reflect the current contents combinationally in the same cycle. With `fetch_valid` low, `pred_hit` is 0.
- R3: An accepted allocation with `alloc_taken`=1 is visible to lookups of its PC from the next cycle, returning `alloc_target`.
- R4: An allocation with `alloc_taken`=0 writes nothing; a later lookup of that PC still misses.
- R5: Allocating a PC that already hits replaces that entry's target and uses no further entry, so at most one entry matches any PC.
- R6: `alloc_ready` is 0 whenever `ovr_valid` is 1, and an allocation offered in such a cycle is not written.
- R7: An override with `ovr_taken`=0 for a PC that hits sets `fix_valid`=1 in that cycle with `fix_pc` = `ovr_pc` + FETCH_BYTES, and the entry misses from the next cycle.
- R8: An override with `ovr_taken`=1 for a PC that hits with a different stored target sets `fix_valid`=1 with `fix_pc` = `ovr_target`, and the entry returns `ovr_target` from the next cycle.
- R9: An override that agrees with the stored entry (taken, same target), or whose PC misses, leaves `fix_valid` at 0 and changes nothing.
- R10: A new PC fills the lowest-numbered invalid entry while any entry is invalid, so an entry freed by R7 is reused before any valid entry is evicted.
- R11: When all entries are valid, a new PC replaces the leaf selected by a binary-tree pseudo-LRU. In that tree, every access sets each node on its path to point at the half it did not use, and victim search follows those pointers from the root. Lookup hits and accepted allocations are the accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch address is being looked up this cycle |
| fetch_pc | input | PC_W | Fetch address |
| pred_hit | output | 1 | Fetch address matches a stored taken branch |
| pred_target | output | PC_W | Predicted next-fetch address on a hit |
| alloc_valid | input | 1 | Branch resolution offered for allocation |
| alloc_ready | output | 1 | Allocation accepted this cycle (low during an override) |
| alloc_pc | input | PC_W | Resolved branch address |
| alloc_target | input | PC_W | Resolved branch target |
| alloc_taken | input | 1 | Branch resolved taken; only taken branches are stored |
| ovr_valid | input | 1 | Main predictor verdict present this cycle |
| ovr_pc | input | PC_W | Branch address the verdict refers to |
| ovr_taken | input | 1 | Main predictor says taken |
| ovr_target | input | PC_W | Main predictor target when taken |
| fix_valid | output | 1 | Main predictor disagrees with a hit; fetch must restart |
| fix_pc | output | PC_W | Restart address for fetch |

## Verification
A corrupted tag or target shows up in the same cycle as a lookup of that PC, as a wrong `pred_hit` or `pred_target`. A stale valid bit shows up as a hit after a drop. A duplicated entry from a missed update, or a victim picked wrongly by the tree, stays hidden until the array is full. It then appears only when a later allocation evicts a PC that should have survived, and that PC misses. For this reason the bench fills all entries, steers the tree with chosen accesses, and then looks up every PC.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

  // Kind of write applied to the entry array in a cycle
  typedef enum logic [1:0] {
    WR_NONE,
    WR_ALLOC,
    WR_RETARGET,
    WR_DROP
  } wr_kind_e;

endpackage

// File: rtl/ttb_cam.sv
module ttb_cam #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]           valid,
  input  logic [ENTRIES-1:0][PC_W-1:0] tags,
  input  logic [PC_W-1:0]              key,
  output logic                         hit,
  output logic [IDX_W-1:0]             idx,
  output logic [ENTRIES-1:0]           match
);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = valid[i] && (tags[i] == key);
    end
  end

  // Match vector is one-hot or empty, so OR-ing indices encodes it
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/ttb_plru.sv
module ttb_plru #(
  parameter int ENTRIES = 64,
  localparam int LVL    = $clog2(ENTRIES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           touch_en,
  input  logic [LVL-1:0] touch_idx,
  output logic [LVL-1:0] victim
);

  // Heap-ordered node bits, root at 1; a 1 points the victim search right
  logic [ENTRIES-1:1] tree_q, tree_d;
  logic [LVL-1:0]     t_node, t_path;
  logic [LVL-1:0]     v_node;
  logic               t_bit, v_bit;

  always_comb begin
    tree_d = tree_q;
    t_node = LVL'(1);
    t_path = touch_idx;
    t_bit  = 1'b0;
    if (touch_en) begin
      for (int l = 0; l < LVL; l++) begin
        t_bit          = t_path[LVL-1];
        t_path         = t_path << 1;
        tree_d[t_node] = ~t_bit;
        t_node         = (t_node << 1) | LVL'(t_bit);
      end
    end
  end

  always_comb begin
    v_node = LVL'(1);
    victim = '0;
    v_bit  = 1'b0;
    for (int l = 0; l < LVL; l++) begin
      v_bit  = tree_q[v_node];
      victim = (victim << 1) | LVL'(v_bit);
      v_node = (v_node << 1) | LVL'(v_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end

  // R11: the leaf just used is never the next victim
  assert_victim_not_recent_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    touch_en |=> (victim != $past(touch_idx)));

endmodule

// File: rtl/taken_target_buffer.sv
module taken_target_buffer #(
  parameter int ENTRIES     = 64,
  parameter int PC_W        = 32,
  parameter int FETCH_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_target,
  input  logic            alloc_valid,
  output logic            alloc_ready,
  input  logic [PC_W-1:0] alloc_pc,
  input  logic [PC_W-1:0] alloc_target,
  input  logic            alloc_taken,
  input  logic            ovr_valid,
  input  logic [PC_W-1:0] ovr_pc,
  input  logic            ovr_taken,
  input  logic [PC_W-1:0] ovr_target,
  output logic            fix_valid,
  output logic [PC_W-1:0] fix_pc
);
  import ttb_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NPORT = 3;   // 0 fetch, 1 allocate, 2 override
  localparam int P_FET = 0;
  localparam int P_ALC = 1;
  localparam int P_OVR = 2;
  localparam logic [PC_W-1:0] STEP = PC_W'(FETCH_BYTES);

  logic [ENTRIES-1:0]           valid_q;
  logic [ENTRIES-1:0][PC_W-1:0] tag_q;
  logic [ENTRIES-1:0][PC_W-1:0] tgt_q;

  logic [NPORT-1:0][PC_W-1:0]    cam_key;
  logic [NPORT-1:0]              cam_hit;
  logic [NPORT-1:0][IDX_W-1:0]   cam_idx;
  logic [NPORT-1:0][ENTRIES-1:0] cam_match;

  logic             disagree, alloc_fire, any_free;
  logic [IDX_W-1:0] free_idx, victim, wr_idx, touch_idx;
  logic             touch_en;
  wr_kind_e         wr_kind;

  assign cam_key[P_FET] = fetch_pc;
  assign cam_key[P_ALC] = alloc_pc;
  assign cam_key[P_OVR] = ovr_pc;

  // One parallel tag comparison per address port
  for (genvar p = 0; p < NPORT; p++) begin : g_cam
    ttb_cam #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_cam (
      .valid (valid_q),
      .tags  (tag_q),
      .key   (cam_key[p]),
      .hit   (cam_hit[p]),
      .idx   (cam_idx[p]),
      .match (cam_match[p])
    );
  end

  // Same-cycle prediction
  assign pred_hit    = fetch_valid && cam_hit[P_FET];
  assign pred_target = tgt_q[cam_idx[P_FET]];

  // Main predictor verdict against the stored entry
  assign disagree  = cam_hit[P_OVR] &&
                     (!ovr_taken || (tgt_q[cam_idx[P_OVR]] != ovr_target));
  assign fix_valid = ovr_valid && disagree;
  assign fix_pc    = ovr_taken ? ovr_target : (ovr_pc + STEP);

  // Override repair owns the write slot
  assign alloc_ready = !ovr_valid;
  assign alloc_fire  = alloc_valid && alloc_ready && alloc_taken;

  // Lowest-numbered free entry
  assign any_free = ~&valid_q;
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    wr_kind = WR_NONE;
    wr_idx  = '0;
    if (fix_valid) begin
      wr_kind = ovr_taken ? WR_RETARGET : WR_DROP;
      wr_idx  = cam_idx[P_OVR];
    end else if (alloc_fire) begin
      wr_kind = WR_ALLOC;
      if (cam_hit[P_ALC]) wr_idx = cam_idx[P_ALC];
      else if (any_free)  wr_idx = free_idx;
      else                wr_idx = victim;
    end
  end

  assign touch_en  = alloc_fire || pred_hit;
  assign touch_idx = alloc_fire ? wr_idx : cam_idx[P_FET];

  ttb_plru #(.ENTRIES(ENTRIES)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .victim    (victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      case (wr_kind)
        WR_ALLOC: valid_q[wr_idx] <= 1'b1;
        WR_DROP:  valid_q[wr_idx] <= 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    case (wr_kind)
      WR_ALLOC: begin
        tag_q[wr_idx] <= alloc_pc;
        tgt_q[wr_idx] <= alloc_target;
      end
      WR_RETARGET: tgt_q[wr_idx] <= ovr_target;
      default: ;
    endcase
  end

  // R5: no PC is ever held twice
  assert_single_match_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $onehot0(cam_match[P_FET]));

  // R3: a taken allocation is found on the following cycle
  assert_alloc_visible_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && alloc_taken) |=>
      (!(fetch_valid && fetch_pc == $past(alloc_pc)) ||
       (pred_hit && pred_target == $past(alloc_target))));

  // R7: a not-taken verdict leaves no hit for that PC
  assert_drop_miss_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (ovr_valid && !ovr_taken) |=>
      !(fetch_valid && fetch_pc == $past(ovr_pc) && pred_hit));

  // R8: a corrected target is what the next lookup returns
  assert_retarget_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (fix_valid && ovr_taken) |=>
      (!(fetch_valid && fetch_pc == $past(ovr_pc)) ||
       (pred_hit && pred_target == $past(ovr_target))));

  // R10: a new PC takes a free slot while one exists
  assert_fill_free_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && alloc_taken && !cam_hit[P_ALC] && any_free) |=>
      ($countones(valid_q) == $countones($past(valid_q)) + 1));

endmodule

// File: tb/sim_taken_target_buffer.sv
module sim_taken_target_buffer;

  localparam int N = 64;
  localparam logic [1:0] OP_LOOK = 2'd0;
  localparam logic [1:0] OP_ALOC = 2'd1;
  localparam logic [1:0] OP_OVRD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic        flag;   // fetch_valid for lookups, taken otherwise
    logic        exp_a;  // expected hit / ready / fix_valid
    logic [31:0] exp_v;  // expected target / fix_pc
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{OP_LOOK, 32'h100, 32'h0,    1'b1, 1'b0, 32'h0,    4'd2},  // R2 empty miss
    '{OP_ALOC, 32'h100, 32'h2000, 1'b1, 1'b1, 32'h0,    4'd3},  // R3
    '{OP_LOOK, 32'h100, 32'h0,    1'b1, 1'b1, 32'h2000, 4'd3},  // R3
    '{OP_ALOC, 32'h200, 32'h3000, 1'b0, 1'b1, 32'h0,    4'd4},  // R4 not taken
    '{OP_LOOK, 32'h200, 32'h0,    1'b1, 1'b0, 32'h0,    4'd4},  // R4
    '{OP_ALOC, 32'h200, 32'h3000, 1'b1, 1'b1, 32'h0,    4'd3},  // R3
    '{OP_LOOK, 32'h200, 32'h0,    1'b1, 1'b1, 32'h3000, 4'd2},  // R2
    '{OP_ALOC, 32'h100, 32'h2400, 1'b1, 1'b1, 32'h0,    4'd5},  // R5 update
    '{OP_LOOK, 32'h100, 32'h0,    1'b1, 1'b1, 32'h2400, 4'd5},  // R5
    '{OP_OVRD, 32'h100, 32'h2400, 1'b1, 1'b0, 32'h0,    4'd9},  // R9 agree
    '{OP_OVRD, 32'h100, 32'h2800, 1'b1, 1'b1, 32'h2800, 4'd8},  // R8
    '{OP_LOOK, 32'h100, 32'h0,    1'b1, 1'b1, 32'h2800, 4'd8},  // R8
    '{OP_OVRD, 32'h200, 32'h0,    1'b0, 1'b1, 32'h204,  4'd7},  // R7
    '{OP_LOOK, 32'h200, 32'h0,    1'b1, 1'b0, 32'h0,    4'd7},  // R7
    '{OP_OVRD, 32'h200, 32'h0,    1'b0, 1'b0, 32'h0,    4'd9},  // R9 miss
    '{OP_LOOK, 32'h100, 32'h0,    1'b0, 1'b0, 32'h0,    4'd2}   // R2 idle
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit;
  logic [31:0] pred_target;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [31:0] alloc_pc = '0;
  logic [31:0] alloc_target = '0;
  logic        alloc_taken = 1'b0;
  logic        ovr_valid = 1'b0;
  logic [31:0] ovr_pc = '0;
  logic        ovr_taken = 1'b0;
  logic [31:0] ovr_target = '0;
  logic        fix_valid;
  logic [31:0] fix_pc;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  taken_target_buffer #(.ENTRIES(N), .PC_W(32), .FETCH_BYTES(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_target(pred_target),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_pc(alloc_pc), .alloc_target(alloc_target), .alloc_taken(alloc_taken),
    .ovr_valid(ovr_valid), .ovr_pc(ovr_pc), .ovr_taken(ovr_taken),
    .ovr_target(ovr_target),
    .fix_valid(fix_valid), .fix_pc(fix_pc)
  );

  function automatic logic [31:0] pcv(input int i);
    return 32'h0001_0000 + 32'(i) * 32'd64;
  endfunction

  function automatic logic [31:0] tgv(input int i);
    return 32'h0004_0000 + 32'(i) * 32'd128;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    fetch_valid = 1'b0;
    alloc_valid = 1'b0;
    alloc_taken = 1'b0;
    ovr_valid   = 1'b0;
    ovr_taken   = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic look(input logic [31:0] pc, input logic fv, input logic eh,
                      input logic [31:0] et, input string req);
    @(negedge clk);
    fetch_valid = fv;
    fetch_pc    = pc;
    #1;
    check(pred_hit === eh, req, "pred_hit", 32'(pred_hit), 32'(eh));
    if (eh) check(pred_target === et, req, "pred_target", pred_target, et);
    @(posedge clk);
    #1 idle();
  endtask

  task automatic alloc(input logic [31:0] pc, input logic [31:0] tgt,
                       input logic tk, input string req);
    @(negedge clk);
    alloc_valid  = 1'b1;
    alloc_pc     = pc;
    alloc_target = tgt;
    alloc_taken  = tk;
    #1;
    check(alloc_ready === 1'b1, req, "alloc_ready", 32'(alloc_ready), 32'd1);
    @(posedge clk);
    #1 idle();
  endtask

  task automatic ovr(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                     input logic ef, input logic [31:0] efp, input string req);
    @(negedge clk);
    ovr_valid  = 1'b1;
    ovr_pc     = pc;
    ovr_taken  = tk;
    ovr_target = tgt;
    #1;
    check(fix_valid === ef, req, "fix_valid", 32'(fix_valid), 32'(ef));
    if (ef) check(fix_pc === efp, req, "fix_pc", fix_pc, efp);
    @(posedge clk);
    #1 idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();

    // Table walk
    for (int v = 0; v < 16; v++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[v].req);
      case (VECS[v].op)
        OP_LOOK: look(VECS[v].pc, VECS[v].flag, VECS[v].exp_a, VECS[v].exp_v, rq);
        OP_ALOC: alloc(VECS[v].pc, VECS[v].tgt, VECS[v].flag, rq);
        default: ovr(VECS[v].pc, VECS[v].flag, VECS[v].tgt, VECS[v].exp_a, VECS[v].exp_v, rq);
      endcase
    end

    // R1: reset empties the buffer
    do_reset();
    #1;
    check(fix_valid === 1'b0, "R1", "fix_valid", 32'(fix_valid), 32'd0);
    check(alloc_ready === 1'b1, "R1", "alloc_ready", 32'(alloc_ready), 32'd1);
    look(32'h100, 1'b1, 1'b0, 32'h0, "R1");

    // R6: override blocks a simultaneous allocation
    @(negedge clk);
    alloc_valid = 1'b1; alloc_pc = 32'h700; alloc_target = 32'h7700; alloc_taken = 1'b1;
    ovr_valid = 1'b1; ovr_pc = 32'h900; ovr_taken = 1'b1; ovr_target = 32'h990;
    #1;
    check(alloc_ready === 1'b0, "R6", "alloc_ready", 32'(alloc_ready), 32'd0);
    @(posedge clk);
    #1 idle();
    look(32'h700, 1'b1, 1'b0, 32'h0, "R6");

    // R5 and R10: update in place, then fill every entry in order
    do_reset();
    alloc(pcv(0), 32'hDEAD_0000, 1'b1, "R5");
    alloc(pcv(0), tgv(0), 1'b1, "R5");
    for (int i = 1; i < N; i++) alloc(pcv(i), tgv(i), 1'b1, "R10");
    for (int i = 0; i < N; i++) look(pcv(i), 1'b1, 1'b1, tgv(i), "R5");

    // R11: sequential use leaves entry 0 least recent
    alloc(32'h9000_0000, 32'hA000_0000, 1'b1, "R11");
    look(pcv(0), 1'b1, 1'b0, 32'h0, "R11");
    look(32'h9000_0000, 1'b1, 1'b1, 32'hA000_0000, "R11");
    look(pcv(32), 1'b1, 1'b1, tgv(32), "R11");
    // Tree now points at entry 16
    alloc(32'h9000_0100, 32'hA000_0100, 1'b1, "R11");
    look(pcv(16), 1'b1, 1'b0, 32'h0, "R11");
    look(32'h9000_0100, 1'b1, 1'b1, 32'hA000_0100, "R11");
    look(pcv(15), 1'b1, 1'b1, tgv(15), "R11");
    look(pcv(17), 1'b1, 1'b1, tgv(17), "R11");

    // R10: a dropped entry is refilled before any eviction
    ovr(pcv(40), 1'b0, 32'h0, 1'b1, pcv(40) + 32'd4, "R7");
    alloc(32'h9000_0200, 32'hA000_0200, 1'b1, "R10");
    for (int i = 1; i < N; i++) begin
      if (i != 16 && i != 40) look(pcv(i), 1'b1, 1'b1, tgv(i), "R10");
    end
    look(pcv(40), 1'b1, 1'b0, 32'h0, "R10");
    look(32'h9000_0200, 1'b1, 1'b1, 32'hA000_0200, "R10");
    look(32'h9000_0000, 1'b1, 1'b1, 32'hA000_0000, "R10");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule